// File: doc/BRIEF.md
# Dual-Pipeline Register Shadowing Router

This block sits between a simple synchronous memory bus and the register files of two display pipelines, called A and B, plus a bank of registers that both pipelines share. The memory space has two register windows, selected by the top two address bits. Window A is at offsets 0x400000 to 0x7FFFFF and window B is at 0xC00000 to 0xFFFFFF. Within a window, the register index is taken from address bits [5:2]. Indices below a parameterised boundary (default 12) are private to one pipeline. Indices at or above the boundary are shared.

A four-bit routing control, reached through an 8-bit I/O port at address 0x3CB, sets how the windows map. With shadowing off, each window reaches its own pipeline. With shadowing on, both windows read from one selected pipeline, and writes are gated by a separate enable for each window.

Small stand-in register banks, written so that they map onto block RAM, sit behind the router so that the routing can be exercised end to end. The bank write strobes are also brought out as pins.

Top module: `shadow_router`

## Requirements
- R1: After synchronous reset, the routing control is 0, `io_rdata` is 0, `mem_rvalid` is 0 and `bank_we` is 0.
- R2: Control layout: bit3 is the shadow enable, bit2 selects pipeline B for reads, bit1 enables writes through window A, and bit0 enables writes through window B.
  - An I/O read at 0x3CB returns {4'b0000, bit3, bit2, bit1, bit0} on `io_rdata` one clock after `io_rd`.
  - An I/O write at 0x3CB stores only `io_wdata[3:0]`, and bits 7..4 always read back as 0.
  - Writes at any other I/O address change nothing, and reads at any other I/O address return 0.
- R3: With bit3 at 0, a private index reached through window A (address bits [23:22] = 01) goes to bank A. A private index reached through window B (bits [23:22] = 11) goes to bank B. Shared indices (index 12 to 15) go to the shared bank through either window, for both reads and writes.
- R4: With bit3 at 0, bits 2..0 have no effect on reads or writes.
- R5: With bit3 at 1, a read of a private index through either window returns bank B when bit2 is 1 and bank A when bit2 is 0. A read of a shared index returns the shared bank.
- R6: With bit3 at 1, a write through window A lands in bank A (private index) or in the shared bank (shared index) when bit1 is 1. When bit1 is 0, the write is dropped.
- R7: With bit3 at 1, a write through window B lands in bank B or in the shared bank when bit0 is 1. When bit0 is 0, the write is dropped.
- R8: An address is unmapped if it lies outside both windows, or if any offset bit outside bits [5:2] is set. A read of an unmapped address returns 0, and a write to it is dropped.
- R9: `mem_rvalid` pulses, and `mem_rdata` carries the data, exactly one clock after `mem_rd`.
- R10: A control write in the same cycle as a memory access does not affect that access. The new setting applies from the next cycle.
- R11: `bank_we` (bit0 = bank A, bit1 = bank B, bit2 = shared bank) has at most one bit set. One clock after `mem_wr` it shows the bank that accepted the write, and it is 0 for a dropped write or when there is no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| mem_addr | input | 24 | Memory bus byte address |
| mem_wdata | input | 32 | Memory bus write data |
| mem_wr | input | 1 | Memory write strobe |
| mem_rd | input | 1 | Memory read strobe |
| mem_rdata | output | 32 | Read data, valid with `mem_rvalid` |
| mem_rvalid | output | 1 | Read data valid, one clock after `mem_rd` |
| bank_we | output | 3 | Registered bank write strobes (A, B, shared) |

## Verification
The control port and the memory bus are independent, so a control write and a memory access can fall in the same cycle. The bench provokes this by raising `io_wr` at 0x3CB together with `mem_rd` in one cycle. It changes the control from "shadow, read B" to all zeros, using a private index whose A and B copies hold different values. The scoreboard entry for that read is computed from the control value as it stood before the write, so returning the new pipeline's data is reported. A following read at the same address then has to show the new mapping.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef struct packed {
    logic shadow_en;
    logic rd_sel_b;
    logic wr_en_a;
    logic wr_en_b;
  } ctrl_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_A    = 2'd1,
    TGT_B    = 2'd2,
    TGT_S    = 2'd3
  } tgt_e;

  localparam logic [1:0] WIN_A = 2'b01;
  localparam logic [1:0] WIN_B = 2'b11;

endpackage

// File: rtl/shadow_ctrl_reg.sv
module shadow_ctrl_reg
  import shadow_pkg::*;
#(
  parameter int          IO_AW   = 16,
  parameter logic [15:0] IO_PORT = 16'h03CB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output ctrl_t            ctrl
);

  localparam logic [7:0]       LIVE_MASK = 8'h0F;
  localparam logic [IO_AW-1:0] PORT      = IO_AW'(IO_PORT);

  logic [7:0] ctrl_q;
  logic       hit;

  assign hit  = (io_addr == PORT);
  assign ctrl = ctrl_t'(ctrl_q[3:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= 8'h00;
      io_rdata <= 8'h00;
    end else begin
      if (io_wr && hit) ctrl_q <= io_wdata & LIVE_MASK;
      io_rdata <= (io_rd && hit) ? ctrl_q : 8'h00;
    end
  end

  // R2: the control holds unless addressed by an I/O write
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && hit) |=> $stable(ctrl_q));

  // R2: reserved bits never appear on the port
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    io_rdata[7:4] == 4'b0000);

endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
  import shadow_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int REG_AW   = 4,
  parameter int EXCL_CNT = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl,
  output tgt_e              rd_tgt,
  output tgt_e              wr_tgt,
  output logic [REG_AW-1:0] idx
);

  localparam int               LOW_W    = ADDR_W - 2;
  localparam logic [LOW_W-1:0] IDX_MASK = LOW_W'(((1 << REG_AW) - 1) << 2);
  localparam logic [REG_AW-1:0] BOUND   = REG_AW'(EXCL_CNT);

  logic [1:0]       window;
  logic [LOW_W-1:0] offset;
  logic             mapped, in_a, in_b, in_any, is_shared, wr_allowed;
  tgt_e             own;

  assign window     = addr[ADDR_W-1 -: 2];
  assign offset     = addr[LOW_W-1:0];
  assign idx        = offset[2 +: REG_AW];
  assign mapped     = ((offset & ~IDX_MASK) == '0);
  assign in_a       = mapped && (window == WIN_A);
  assign in_b       = mapped && (window == WIN_B);
  assign in_any     = in_a || in_b;
  assign is_shared  = (idx >= BOUND);
  assign own        = in_a ? TGT_A : TGT_B;
  assign wr_allowed = !ctrl.shadow_en || (in_a ? ctrl.wr_en_a : ctrl.wr_en_b);

  always_comb begin
    if (!in_any)             rd_tgt = TGT_NONE;
    else if (is_shared)      rd_tgt = TGT_S;
    else if (ctrl.shadow_en) rd_tgt = ctrl.rd_sel_b ? TGT_B : TGT_A;
    else                     rd_tgt = own;
  end

  always_comb begin
    if (!in_any || !wr_allowed) wr_tgt = TGT_NONE;
    else if (is_shared)         wr_tgt = TGT_S;
    else                        wr_tgt = own;
  end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 12,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/shadow_router.sv
module shadow_router
  import shadow_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          DATA_W   = 32,
  parameter int          IO_AW    = 16,
  parameter logic [15:0] IO_PORT  = 16'h03CB,
  parameter int          REG_AW   = 4,
  parameter int          EXCL_CNT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wr,
  input  logic              mem_rd,
  output logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rvalid,
  output logic [2:0]        bank_we
);

  localparam int SHARED_CNT = (1 << REG_AW) - EXCL_CNT;
  localparam int S_AW       = (SHARED_CNT > 1) ? $clog2(SHARED_CNT) : 1;
  localparam int E_AW       = REG_AW;

  ctrl_t             ctrl;
  tgt_e              rd_tgt, wr_tgt, rd_tgt_q;
  logic [REG_AW-1:0] idx;
  logic [S_AW-1:0]   s_idx;
  logic [DATA_W-1:0] excl_rdata [2];
  logic [DATA_W-1:0] shared_rdata;

  shadow_ctrl_reg #(
    .IO_AW   (IO_AW),
    .IO_PORT (IO_PORT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .ctrl     (ctrl)
  );

  shadow_decode #(
    .ADDR_W   (ADDR_W),
    .REG_AW   (REG_AW),
    .EXCL_CNT (EXCL_CNT)
  ) u_decode (
    .addr   (mem_addr),
    .ctrl   (ctrl),
    .rd_tgt (rd_tgt),
    .wr_tgt (wr_tgt),
    .idx    (idx)
  );

  assign s_idx = S_AW'(idx - REG_AW'(EXCL_CNT));

  // one private bank per pipeline
  for (genvar g = 0; g < 2; g++) begin : g_excl
    localparam tgt_e MY_TGT = (g == 0) ? TGT_A : TGT_B;
    shadow_bank #(
      .DATA_W (DATA_W),
      .DEPTH  (EXCL_CNT),
      .AW     (E_AW)
    ) u_bank (
      .clk   (clk),
      .we    (mem_wr && (wr_tgt == MY_TGT)),
      .re    (mem_rd && (rd_tgt == MY_TGT)),
      .addr  (idx),
      .wdata (mem_wdata),
      .rdata (excl_rdata[g])
    );
  end

  shadow_bank #(
    .DATA_W (DATA_W),
    .DEPTH  (SHARED_CNT),
    .AW     (S_AW)
  ) u_shared (
    .clk   (clk),
    .we    (mem_wr && (wr_tgt == TGT_S)),
    .re    (mem_rd && (rd_tgt == TGT_S)),
    .addr  (s_idx),
    .wdata (mem_wdata),
    .rdata (shared_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tgt_q   <= TGT_NONE;
      mem_rvalid <= 1'b0;
      bank_we    <= 3'b000;
    end else begin
      rd_tgt_q   <= mem_rd ? rd_tgt : TGT_NONE;
      mem_rvalid <= mem_rd;
      bank_we    <= {mem_wr && (wr_tgt == TGT_S),
                     mem_wr && (wr_tgt == TGT_B),
                     mem_wr && (wr_tgt == TGT_A)};
    end
  end

  always_comb begin
    unique case (rd_tgt_q)
      TGT_A:   mem_rdata = excl_rdata[0];
      TGT_B:   mem_rdata = excl_rdata[1];
      TGT_S:   mem_rdata = shared_rdata;
      default: mem_rdata = '0;
    endcase
  end

  // R9: read data valid one clock after the strobe
  a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> mem_rvalid);

  // R11: at most one bank strobe
  a_r11_we_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));

  // R11: no strobe without a bus write
  a_r11_no_write_quiet: assert property (@(posedge clk) disable iff (rst)
    !mem_wr |=> (bank_we == 3'b000));

  // R4: unshadowed private reads follow the window
  a_r4_own_window: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.shadow_en && (rd_tgt == TGT_A || rd_tgt == TGT_B)) |->
      (rd_tgt == ((mem_addr[ADDR_W-1 -: 2] == WIN_A) ? TGT_A : TGT_B)));

  // R5: shadowed private reads follow the read select
  a_r5_shadow_read: assert property (@(posedge clk) disable iff (rst)
    (ctrl.shadow_en && (rd_tgt == TGT_A || rd_tgt == TGT_B)) |->
      (rd_tgt == (ctrl.rd_sel_b ? TGT_B : TGT_A)));

  // R6: window A writes blocked while its enable is clear
  a_r6_gate_a: assert property (@(posedge clk) disable iff (rst)
    (ctrl.shadow_en && !ctrl.wr_en_a && mem_addr[ADDR_W-1 -: 2] == WIN_A) |->
      (wr_tgt == TGT_NONE));

  // R7: window B writes blocked while its enable is clear
  a_r7_gate_b: assert property (@(posedge clk) disable iff (rst)
    (ctrl.shadow_en && !ctrl.wr_en_b && mem_addr[ADDR_W-1 -: 2] == WIN_B) |->
      (wr_tgt == TGT_NONE));

endmodule

// File: tb/shadow_router_tb.sv
module shadow_router_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_wr, mem_rd, mem_rvalid;
  logic [2:0]  bank_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  ctrl_m;
  logic [31:0] ma [16];
  logic [31:0] mb [16];
  logic [31:0] ms [16];

  typedef struct {
    logic [31:0] d;
    string       r;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_router u_dut (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .bank_we    (bank_we)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // 0 none, 1 bank A, 2 bank B, 3 shared
  function automatic int route(input logic [23:0] a, input logic [3:0] c, input bit wr);
    bit ok, is_a, is_b, sh;
    ok   = ((a[21:0] & ~22'h3C) == 22'h0);
    is_a = ok && (a[23:22] == 2'b01);
    is_b = ok && (a[23:22] == 2'b11);
    sh   = (a[5:2] >= 4'd12);
    if (!is_a && !is_b) return 0;
    if (!wr) begin
      if (sh) return 3;
      if (c[3]) return c[2] ? 2 : 1;
      return is_a ? 1 : 2;
    end
    if (c[3] && !(is_a ? c[1] : c[0])) return 0;
    if (sh) return 3;
    return is_a ? 1 : 2;
  endfunction

  function automatic logic [31:0] model_data(input int t, input logic [3:0] i);
    case (t)
      1: return ma[i];
      2: return mb[i];
      3: return ms[i];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [2:0] exp_we(input int t);
    case (t)
      1: return 3'b001;
      2: return 3'b010;
      3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [23:0] wa(input int i);
    return {2'b01, 22'(i << 2)};
  endfunction

  function automatic logic [23:0] wb(input int i);
    return {2'b11, 22'(i << 2)};
  endfunction

  task automatic mwrite(input logic [23:0] a, input logic [31:0] d, input string r);
    int t;
    t = route(a, ctrl_m, 1'b1);
    @(negedge clk);
    mem_addr = a; mem_wdata = d; mem_wr = 1'b1;
    @(negedge clk);
    mem_wr = 1'b0;
    chk(r, {29'b0, bank_we}, {29'b0, exp_we(t)});
    case (t)
      1: ma[a[5:2]] = d;
      2: mb[a[5:2]] = d;
      3: ms[a[5:2]] = d;
      default: ;
    endcase
  endtask

  task automatic mread(input logic [23:0] a, input string r);
    int t;
    exp_t e;
    t = route(a, ctrl_m, 1'b0);
    @(negedge clk);
    mem_addr = a; mem_rd = 1'b1;
    e.d = model_data(t, a[5:2]);
    e.r = r;
    sb_q.push_back(e);
    @(negedge clk);
    mem_rd = 1'b0;
    chk({r, " rvalid"}, {31'b0, mem_rvalid}, 32'd1);
  endtask

  task automatic iowrite(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == 16'h03CB) ctrl_m = v[3:0];
  endtask

  task automatic ioread(input logic [15:0] a, input string r);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk(r, {24'b0, io_rdata}, (a == 16'h03CB) ? {28'b0, ctrl_m} : 32'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (!rst && mem_rvalid) begin
      if (sb_q.size() == 0) chk("R9 unexpected rvalid", 32'd1, 32'd0);
      else begin
        e = sb_q.pop_front();
        chk(e.r, mem_rdata, e.d);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin : main
    rst = 1'b1;
    io_addr = 16'h0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = 8'h0;
    mem_addr = 24'h0; mem_wdata = 32'h0; mem_wr = 1'b0; mem_rd = 1'b0;
    ctrl_m = 4'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 io_rdata", {24'b0, io_rdata}, 32'h0);
    chk("R1 rvalid", {31'b0, mem_rvalid}, 32'h0);
    chk("R1 bank_we", {29'b0, bank_we}, 32'h0);
    ioread(16'h03CB, "R1 control after reset");

    // R3: separate mapping, fill both windows
    for (int i = 0; i < 16; i++) mwrite(wa(i), 32'hA000_0000 + i, "R3 write A window");
    for (int i = 0; i < 16; i++) mwrite(wb(i), 32'hB000_0000 + i, "R3 write B window");
    for (int i = 0; i < 16; i++) mread(wa(i), "R3 read A window");
    for (int i = 0; i < 16; i++) mread(wb(i), "R3 read B window");

    // R4: low bits without shadow enable change nothing
    iowrite(16'h03CB, 8'h07);
    ioread(16'h03CB, "R2 readback 0x07");
    mread(wa(0), "R4 A window private");
    mread(wb(0), "R4 B window private");
    mwrite(wa(1), 32'h1111_AAAA, "R4 write A window");
    mwrite(wb(1), 32'h1111_BBBB, "R4 write B window");
    mread(wa(1), "R4 readback A");
    mread(wb(1), "R4 readback B");

    // R2: reserved bits and foreign addresses
    iowrite(16'h03CB, 8'hF8);
    ioread(16'h03CB, "R2 reserved bits dropped");
    iowrite(16'h03CC, 8'h0F);
    ioread(16'h03CB, "R2 foreign write ignored");
    ioread(16'h03CC, "R2 foreign read zero");

    // R5: shadow on, read A through both windows
    mread(wb(2), "R5 B window reads A");
    mread(wa(2), "R5 A window reads A");
    mread(wb(13), "R5 shared through B");

    // R6/R7: writes gated
    mwrite(wa(3), 32'hDEAD_0003, "R6 blocked A write");
    mwrite(wb(3), 32'hDEAD_1003, "R7 blocked B write");
    mwrite(wb(14), 32'hDEAD_100E, "R7 blocked shared write");
    mread(wa(3), "R6 A unchanged");
    mread(wa(14), "R7 shared unchanged");
    iowrite(16'h03CB, 8'h0A);
    mwrite(wa(3), 32'h5555_0003, "R6 enabled A write");
    mwrite(wa(12), 32'h5555_000C, "R6 enabled shared write");
    mwrite(wb(3), 32'h6666_0003, "R7 still blocked");
    mread(wb(3), "R6 A data via B window");
    mread(wb(12), "R6 shared readback");

    iowrite(16'h03CB, 8'h0D);
    mread(wa(4), "R5 A window reads B");
    mwrite(wb(5), 32'h7777_0005, "R7 enabled B write");
    mwrite(wa(5), 32'h8888_0005, "R6 blocked with wr_en_a clear");
    mread(wa(5), "R7 B readback");

    // R8: unmapped addresses
    mread(24'h000010, "R8 low space read");
    mread(24'h800004, "R8 gap read");
    mread(24'h400001, "R8 unaligned read");
    mread(24'h400100, "R8 stray offset read");
    mwrite(24'h800004, 32'hFFFF_FFFF, "R8 gap write dropped");
    mwrite(24'hC00140, 32'hFFFF_FFFF, "R8 stray write dropped");

    // R10: control write in the same cycle as a read
    begin
      int   t;
      exp_t e;
      t = route(wa(4), ctrl_m, 1'b0);
      @(negedge clk);
      io_addr = 16'h03CB; io_wdata = 8'h00; io_wr = 1'b1;
      mem_addr = wa(4); mem_rd = 1'b1;
      e.d = model_data(t, 4'd4);
      e.r = "R10 same-cycle read uses old control";
      sb_q.push_back(e);
      @(negedge clk);
      io_wr = 1'b0; mem_rd = 1'b0;
      ctrl_m = 4'h0;
    end
    mread(wa(4), "R10 new control applies");
    ioread(16'h03CB, "R10 control updated");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", sb_q.size(), 32'd0);
    done = 1;
    finish_run();
  end

endmodule